// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small CPU core and carries out the stack and segment work needed to enter an interrupt handler, enter the divide-by-zero trap handler, and come back from either one. The core raises one of four requests and supplies its current program counter and flags. The sequencer then pushes or pops bytes through a byte-wide memory port, fetches the two-byte handler vector when entering, and presents the new program counter together with a one-cycle done pulse. After a return-from-interrupt it also hands back the restored flags.

The block holds the code segment, the interrupt segment, a vector base and a mode bit. Software writes them through a small configuration port. Addresses are 22 bits wide: a 6-bit segment joined to a 16-bit offset.

In mode 0 the code segment is neither saved nor changed. While a handler runs, instruction fetch uses the interrupt segment. In mode 1 the code segment is stacked on entry, loaded from the interrupt segment, and restored on return.

Top module: `irq_seq`

## Requirements
- R1: After reset the block is idle and busy is 0. Done, the memory strobes and the fetch segment are all 0. The mode bit is 0.
- R2: In mode 0, interrupt entry pushes three bytes: PC low, then PC high, then flags. While the handler runs, fetch_seg equals the interrupt segment, and a software write to the code segment does not change fetch_seg.
- R3: In mode 1, interrupt entry pushes four bytes: the code segment (zero-extended to 8 bits), then PC low, PC high and flags. At done the code segment takes the interrupt segment's value.
- R4: Return-from-interrupt pops bytes in the exact reverse of the push order: flags, PC high, PC low, and in mode 1 also the code segment. It presents the restored PC and flags, raises flags_load only in its done cycle, and returns fetch_seg to the code segment.
- R5: The interrupt vector is read at {interrupt segment, 8'h00, vector base bits 7:4, channel (3 bits), 0}. The low byte comes first, from the even address; the high byte comes from the next address. new_pc is {high, low}.
- R6: Divide-by-zero trap entry pushes only PC low and then PC high, with no flags. It reads its vector at offsets 0002h and 0003h of the current fetch segment.
- R7: A plain return pops two bytes: first PC high, then PC low. It presents {high, low} as new_pc and does not raise flags_load.
- R8: busy is high from the cycle after a request is accepted through the done cycle. done lasts exactly one cycle. Requests that arrive while busy is high are ignored.
- R9: Among requests present in the same idle cycle, trap wins over interrupt, interrupt over return-from-interrupt, and return-from-interrupt over plain return.
- R10: Configuration writes are taken only while idle. cfg_sel selects the target: 0 is the code segment, 1 the interrupt segment, 2 the vector base, and 3 the mode (bit 0).
- R11: The stack lives in segment 0 and grows downward. A push writes at sp-1 and then decrements sp. A pop reads at sp and then increments sp. sp starts at 0000h, so the first push lands at FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 1 | Interrupt entry request |
| irq_chan | input | 3 | Requesting channel index |
| trap_req | input | 1 | Divide-by-zero trap request |
| iret_req | input | 1 | Return-from-interrupt request |
| ret_req | input | 1 | Plain return request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_pc | input | 16 | Current program counter |
| cpu_flags | input | 8 | Current flag register |
| mem_rdata | input | 8 | Memory read data (same cycle) |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Memory byte read strobe |
| mem_addr | output | 22 | Memory byte address |
| mem_wdata | output | 8 | Stack write data |
| fetch_seg | output | 6 | Segment for instruction fetch |
| new_pc | output | 16 | Program counter to load |
| done | output | 1 | One-cycle completion pulse |
| flags_load | output | 1 | Load flags_out into the core |
| flags_out | output | 8 | Restored flags |

## Verification
Two kinds of request can arrive in the same idle cycle, and the bench provokes this by raising the trap and interrupt requests together. It judges the result by the stack traffic and the vector address: exactly two pushed bytes and a read at offset 0002h of the code segment mark the trap as the winner. While that trap sequence runs, the bench also raises an interrupt, a return-from-interrupt and a code segment write. It then confirms that there is only one done pulse, no further stack traffic, and an unchanged fetch segment.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int CW = 3,
  parameter int SEGW = 6,
  parameter logic [SEGW-1:0] STK_SEG = '0,
  parameter logic [15:0] SP_INIT = 16'h0000,
  localparam int AW = SEGW + 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic [CW-1:0]   irq_chan,
  input  logic            trap_req,
  input  logic            iret_req,
  input  logic            ret_req,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic [15:0]     cpu_pc,
  input  logic [7:0]      cpu_flags,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            mem_we,
  output logic            mem_re,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  output logic [SEGW-1:0] fetch_seg,
  output logic [15:0]     new_pc,
  output logic            done,
  output logic            flags_load,
  output logic [7:0]      flags_out
);
  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_VLO, S_VHI, S_POP, S_FIN} st_t;
  typedef enum logic [1:0] {OP_IRQ, OP_TRAP, OP_IRET, OP_RET} op_t;

  st_t             st;
  op_t             op;
  logic [1:0]      slot;
  logic [15:0]     sp, pcr;
  logic [SEGW-1:0] csr, isr;
  logic [7:0]      vbase, flg, lo, hi;
  logic            mode, svc;
  logic [CW-1:0]   chan;
  logic [AW-1:0]   vaddr;
  logic [1:0]      last_push, last_pop;

  assign last_push = (op == OP_TRAP) ? 2'd2 : 2'd3;
  assign last_pop  = (op == OP_IRET && mode) ? 2'd0 : 2'd1;
  assign vaddr = (op == OP_TRAP) ? {fetch_seg, 16'h0002}
                                 : {isr, 8'h00, vbase[7:CW+1], chan, 1'b0};

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
  assign mem_we     = (st == S_PUSH);
  assign mem_re     = (st == S_VLO) || (st == S_VHI) || (st == S_POP);
  assign fetch_seg  = (svc && !mode) ? isr : csr;
  assign new_pc     = {hi, lo};
  assign flags_out  = flg;
  assign flags_load = done && (op == OP_IRET);

  always_comb begin
    case (slot)
      2'd0:    mem_wdata = {{(8-SEGW){1'b0}}, csr};
      2'd1:    mem_wdata = pcr[7:0];
      2'd2:    mem_wdata = pcr[15:8];
      default: mem_wdata = flg;
    endcase
    case (st)
      S_PUSH:  mem_addr = {STK_SEG, sp - 16'd1};
      S_POP:   mem_addr = {STK_SEG, sp};
      S_VLO:   mem_addr = vaddr;
      S_VHI:   mem_addr = {vaddr[AW-1:1], 1'b1};
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_IRQ; slot <= '0; sp <= SP_INIT; pcr <= '0;
      csr <= '0; isr <= '0; vbase <= '0; flg <= '0; lo <= '0; hi <= '0;
      mode <= 1'b0; svc <= 1'b0; chan <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cfg_we) begin
            case (cfg_sel)
              2'd0:    csr   <= cfg_wdata[SEGW-1:0];
              2'd1:    isr   <= cfg_wdata[SEGW-1:0];
              2'd2:    vbase <= cfg_wdata;
              default: mode  <= cfg_wdata[0];
            endcase
          end
          pcr <= cpu_pc;
          flg <= cpu_flags;
          if (trap_req) begin
            op <= OP_TRAP; slot <= 2'd1; st <= S_PUSH;
          end else if (irq_req) begin
            op <= OP_IRQ; slot <= mode ? 2'd0 : 2'd1; st <= S_PUSH; chan <= irq_chan;
          end else if (iret_req) begin
            op <= OP_IRET; slot <= 2'd3; st <= S_POP;
          end else if (ret_req) begin
            op <= OP_RET; slot <= 2'd2; st <= S_POP;
          end
        end
        S_PUSH: begin
          sp   <= sp - 16'd1;
          slot <= slot + 2'd1;
          if (slot == last_push) st <= S_VLO;
        end
        S_VLO: begin lo <= mem_rdata; st <= S_VHI; end
        S_VHI: begin hi <= mem_rdata; st <= S_FIN; end
        S_POP: begin
          sp <= sp + 16'd1;
          case (slot)
            2'd3:    flg <= mem_rdata;
            2'd2:    hi  <= mem_rdata;
            2'd1:    lo  <= mem_rdata;
            default: csr <= mem_rdata[SEGW-1:0];
          endcase
          if (slot == last_pop) st <= S_FIN;
          else slot <= slot - 2'd1;
        end
        S_FIN: begin
          st <= S_IDLE;
          if (op == OP_IRQ) begin
            svc <= 1'b1;
            if (mode) csr <= isr;
          end
          if (op == OP_IRET) svc <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] stk_off,
  input logic        flags_load,
  input logic        any_req
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R8
  AST_IDLE_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_we && !mem_re)); // R1
  AST_NO_WE_RE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R11
  AST_PUSH_DOWNWARD: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && $past(mem_we)) |-> (stk_off == $past(stk_off) - 16'd1)); // R11
  AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) flags_load |-> done); // R4
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(any_req)); // R9
endmodule

bind irq_seq irq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
  .mem_re(mem_re), .stk_off(mem_addr[15:0]), .flags_load(flags_load),
  .any_req(irq_req | trap_req | iret_req | ret_req)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic irq_req = 0, trap_req = 0, iret_req = 0, ret_req = 0, cfg_we = 0;
  logic [2:0] irq_chan = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0, cpu_flags = 0, mem_rdata = 0;
  logic [15:0] cpu_pc = 0;
  logic busy, mem_we, mem_re, done, flags_load;
  logic [21:0] mem_addr;
  logic [7:0] mem_wdata, flags_out;
  logic [5:0] fetch_seg;
  logic [15:0] new_pc;

  irq_seq u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  logic [7:0]  mem [logic [21:0]];
  logic [21:0] wa [8];
  logic [7:0]  wd [8];
  logic [21:0] ra [8];
  int nw, nr, bcnt, dn, total, fails;
  logic [15:0] pc_seen;
  logic [7:0]  fl_seen;
  logic        fl_ld_seen;

  always @(negedge clk) begin
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      if (nw < 8) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
      nw++;
    end
    if (mem_re) begin
      mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
      if (nr < 8) ra[nr] = mem_addr;
      nr++;
    end
    if (busy) bcnt++;
    if (done) begin dn++; pc_seen = new_pc; fl_seen = flags_out; fl_ld_seen = flags_load; end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d; tick(); cfg_we = 0;
  endtask

  task automatic clr();
    nw = 0; nr = 0; bcnt = 0; dn = 0; fl_ld_seen = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60 && dn == 0; i++) tick();
    chk("R8", "done seen", dn, 1);
    tick();
    chk("R8", "busy after done", busy, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "mem_re", mem_re, 0);
    chk("R1", "fetch_seg", fetch_seg, 0);
  endtask

  task automatic t_irq_mode0();
    cfg(0, 8'h05); cfg(1, 8'h09); cfg(2, 8'hA0);
    mem[22'h0900A6] = 8'h78; mem[22'h0900A7] = 8'h56;
    cpu_pc = 16'h1234; cpu_flags = 8'h5A; clr();
    irq_req = 1; irq_chan = 3; tick(); irq_req = 0;
    wait_done();
    chk("R2", "push count", nw, 3);
    chk("R11", "push0 addr", wa[0], 22'h00FFFF);
    chk("R2", "push0 PCL", wd[0], 8'h34);
    chk("R2", "push1 PCH", wd[1], 8'h12);
    chk("R2", "push2 flags", wd[2], 8'h5A);
    chk("R11", "push2 addr", wa[2], 22'h00FFFD);
    chk("R5", "vec lo addr", ra[0], 22'h0900A6);
    chk("R5", "vec hi addr", ra[1], 22'h0900A7);
    chk("R5", "new_pc", pc_seen, 16'h5678);
    chk("R8", "busy cycles", bcnt, 6);
    chk("R2", "fetch_seg in service", fetch_seg, 6'h09);
    cfg(0, 8'h07);
    chk("R2", "fetch_seg after csr write", fetch_seg, 6'h09);
  endtask

  task automatic t_iret_mode0();
    clr(); iret_req = 1; tick(); iret_req = 0;
    wait_done();
    chk("R4", "pop count", nr, 3);
    chk("R4", "pop0 addr", ra[0], 22'h00FFFD);
    chk("R4", "pop2 addr", ra[2], 22'h00FFFF);
    chk("R4", "pc", pc_seen, 16'h1234);
    chk("R4", "flags", fl_seen, 8'h5A);
    chk("R4", "flags_load", fl_ld_seen, 1);
    chk("R4", "fetch_seg back", fetch_seg, 6'h07);
  endtask

  task automatic t_irq_mode1();
    cfg(3, 8'h01); cfg(1, 8'h11); cfg(2, 8'h30);
    mem[22'h11003A] = 8'hCD; mem[22'h11003B] = 8'hAB;
    cpu_pc = 16'hBEEF; cpu_flags = 8'h81; clr();
    irq_req = 1; irq_chan = 5; tick(); irq_req = 0;
    wait_done();
    chk("R3", "push count", nw, 4);
    chk("R3", "push0 csr", wd[0], 8'h07);
    chk("R3", "push1 PCL", wd[1], 8'hEF);
    chk("R3", "push2 PCH", wd[2], 8'hBE);
    chk("R3", "push3 flags", wd[3], 8'h81);
    chk("R11", "push3 addr", wa[3], 22'h00FFFC);
    chk("R5", "vec lo addr", ra[0], 22'h11003A);
    chk("R5", "new_pc", pc_seen, 16'hABCD);
    chk("R8", "busy cycles", bcnt, 7);
    chk("R3", "csr loaded", fetch_seg, 6'h11);
  endtask

  task automatic t_iret_mode1();
    clr(); iret_req = 1; tick(); iret_req = 0;
    wait_done();
    chk("R4", "pop count m1", nr, 4);
    chk("R4", "last pop addr", ra[3], 22'h00FFFF);
    chk("R4", "pc m1", pc_seen, 16'hBEEF);
    chk("R4", "flags m1", fl_seen, 8'h81);
    chk("R4", "csr restored", fetch_seg, 6'h07);
  endtask

  task automatic t_trap();
    mem[22'h070002] = 8'h22; mem[22'h070003] = 8'h44;
    cpu_pc = 16'h3344; cpu_flags = 8'hFF; clr();
    trap_req = 1; tick(); trap_req = 0;
    wait_done();
    chk("R6", "push count", nw, 2);
    chk("R6", "push0 PCL", wd[0], 8'h44);
    chk("R6", "push1 PCH", wd[1], 8'h33);
    chk("R6", "vec addr", ra[0], 22'h070002);
    chk("R6", "new_pc", pc_seen, 16'h4422);
    chk("R6", "no flags_load", fl_ld_seen, 0);
    chk("R8", "busy cycles", bcnt, 5);
  endtask

  task automatic t_ret();
    clr(); ret_req = 1; tick(); ret_req = 0;
    wait_done();
    chk("R7", "pop count", nr, 2);
    chk("R7", "pop0 addr", ra[0], 22'h00FFFE);
    chk("R7", "pc", pc_seen, 16'h3344);
    chk("R7", "no flags_load", fl_ld_seen, 0);
    chk("R8", "busy cycles", bcnt, 3);
  endtask

  task automatic t_collide();
    cpu_pc = 16'h3344; clr();
    trap_req = 1; irq_req = 1; irq_chan = 3; tick(); trap_req = 0; irq_req = 0;
    tick();
    irq_req = 1; iret_req = 1; cfg_we = 1; cfg_sel = 0; cfg_wdata = 8'h3F;
    tick();
    irq_req = 0; iret_req = 0; cfg_we = 0;
    wait_done();
    for (int i = 0; i < 4; i++) tick();
    chk("R9", "trap wins: pushes", nw, 2);
    chk("R9", "trap wins: vec addr", ra[0], 22'h070002);
    chk("R8", "ignored reqs: one done", dn, 1);
    chk("R10", "busy cfg write ignored", fetch_seg, 6'h07);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    total = 0; fails = 0; clr();
    tick(); tick(); t_reset();
    rst_n = 1; tick(); t_reset();
    t_irq_mode0();
    t_iret_mode0();
    t_irq_mode1();
    t_iret_mode1();
    t_trap();
    t_ret();
    t_collide();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule